// File: doc/BRIEF.md
# Two-Thread Precision-Sharing MAC Element

This block is one processing element of an output-stationary systolic array that runs two independent operand streams, called threads, on a single 8-bit multiply datapath. Each clock cycle it accepts one unsigned activation and one signed weight for each thread. It registers both operand pairs toward its right and lower neighbours, and it adds each thread's product into that thread's own accumulator. Neither thread is ever held back.

The element needs no arbitration queue. When only one thread has useful work (valid, with a non-zero activation and a non-zero weight), that thread gets the whole multiplier and an exact product. When both threads have useful work, the multiplier splits into two 4-bit by 8-bit halves, one for each thread. Each half takes whichever operand of its thread fits in four bits. When neither operand fits, the activation is coarsened to four bits and the product is rescaled. A debug flag marks every cycle in which such a coarsened product was used, so that a bench can tell approximate results from exact ones.

The array controller uses a per-thread clear to start a new output tile. It raises drain to read both partial sums.

Top module: `dual_lane_pe`

## Requirements
- R1: `act_out`, `wgt_out` and `vld_out` equal the values of `act_in`, `wgt_in` and `vld_in` from the previous clock edge, for both threads and in every sharing mode. After reset they are zero.
- R2: A thread is live when its valid bit is 1 and both its activation and its weight are non-zero. A thread that is not live adds zero. When exactly one thread is live, that thread adds the exact product of its activation (unsigned, 0..255) and its weight (two's complement, -128..127).
- R3: An invalid thread adds nothing and its accumulator keeps its value, even when its operands are non-zero. The other thread still gets the exact full-precision product.
- R4: When both threads are live, a thread whose activation is below 16 adds its exact product.
- R5: When both threads are live, a thread whose activation is 16 or more and whose weight is in 0..15 adds its exact product.
- R6: When both threads are live, a thread whose activation is 16 or more and whose weight is negative or above 15 adds r*w*16. Here r = floor((activation+8)/16), saturated at 15.
- R7: `approx_flag` is 1 in exactly those cycles in which a thread takes the R6 path. It is combinational on the current inputs.
- R8: When `clr_in[t]` is 1, thread t's accumulator is loaded with that cycle's product of thread t (zero when thread t is not live). The other thread is not affected.
- R9: While `drain_in` is 1, `acc_out` shows thread 0's accumulator in bits 23:0 and thread 1's in bits 47:24, as of the last clock edge. While `drain_in` is 0, `acc_out` is zero.
- R10: Each accumulator is 24-bit two's complement and wraps modulo 2^24 on overflow. Reset clears both accumulators to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_in | input | 16 | Activations, thread 0 in bits 7:0, thread 1 in bits 15:8, unsigned |
| wgt_in | input | 16 | Weights, thread 0 in bits 7:0, thread 1 in bits 15:8, signed |
| vld_in | input | 2 | Per-thread operand valid, bit t for thread t |
| clr_in | input | 2 | Per-thread accumulator restart |
| drain_in | input | 1 | Present accumulators on acc_out |
| act_out | output | 16 | Registered activations toward the right neighbour |
| wgt_out | output | 16 | Registered weights toward the lower neighbour |
| vld_out | output | 2 | Registered valid bits travelling with the activations |
| acc_out | output | 48 | Drained accumulators, thread 0 low, thread 1 high |
| approx_flag | output | 1 | Some product in this cycle was computed at reduced precision |

## Verification
The properties assume that every input is a known value from the first rising edge after reset is released. They also assume that each input stays steady across a rising edge, because the hold and clear properties compare values one edge apart. The bench changes every input only at falling edges and keeps reset low until the inputs have settled at zero. It also keeps `drain_in` high in every scenario that checks accumulator contents, so that the R3 hold property and the R8 clear property both see the drained values they relate.

// File: rtl/dlpe_pkg.sv
package dlpe_pkg;

   // how the shared multiplier halves are assigned in a given cycle
   typedef enum logic [1:0] {
      SHARE_IDLE  = 2'd0,
      SHARE_SOLO0 = 2'd1,
      SHARE_SOLO1 = 2'd2,
      SHARE_SPLIT = 2'd3
   } share_mode_e;

   localparam int unsigned LANES = 2;

endpackage

// File: rtl/dlpe_lane_prep.sv
module dlpe_lane_prep #(
   parameter int unsigned ACT_W      = 8,
   parameter int unsigned WGT_W      = 8,
   parameter bit          ROUND_NEAR = 1'b1,
   localparam int unsigned NIB_W     = ACT_W / 2,
   localparam int unsigned WIDE_W    = ACT_W + 1
) (
   input  logic [ACT_W-1:0]         act,
   input  logic [WGT_W-1:0]         wgt,
   output logic [NIB_W-1:0]         nib,
   output logic signed [WIDE_W-1:0] wide,
   output logic                     shift_up,
   output logic                     reduced
);

   logic [NIB_W-1:0]         red_nib;
   logic signed [WIDE_W-1:0] wgt_sx;
   logic                     act_fits;
   logic                     wgt_fits;

   assign wgt_sx   = {{(WIDE_W-WGT_W){wgt[WGT_W-1]}}, wgt};
   assign act_fits = (act[ACT_W-1:NIB_W] == '0);
   assign wgt_fits = (wgt[WGT_W-1:NIB_W] == '0);

   // coarsening variant for the activation when no operand fits
   if (ROUND_NEAR) begin : g_round
      logic [ACT_W:0]   biased;
      logic [NIB_W:0]   upper;
      assign biased  = {1'b0, act} + (ACT_W+1)'(1 << (NIB_W-1));
      assign upper   = biased[ACT_W:NIB_W];
      assign red_nib = upper[NIB_W] ? {NIB_W{1'b1}} : upper[NIB_W-1:0];
   end else begin : g_trunc
      assign red_nib = act[ACT_W-1:NIB_W];
   end

   always_comb begin
      if (act_fits) begin
         nib      = act[NIB_W-1:0];
         wide     = wgt_sx;
         shift_up = 1'b0;
         reduced  = 1'b0;
      end else if (wgt_fits) begin
         nib      = wgt[NIB_W-1:0];
         wide     = {{(WIDE_W-ACT_W){1'b0}}, act};
         shift_up = 1'b0;
         reduced  = 1'b0;
      end else begin
         nib      = red_nib;
         wide     = wgt_sx;
         shift_up = 1'b1;
         reduced  = 1'b1;
      end
   end

endmodule

// File: rtl/dlpe_nibble_mul.sv
module dlpe_nibble_mul #(
   parameter int unsigned NIB_W  = 4,
   parameter int unsigned WIDE_W = 9,
   localparam int unsigned MUL_W = NIB_W + WIDE_W + 1
) (
   input  logic [NIB_W-1:0]         nib,
   input  logic signed [WIDE_W-1:0] wide,
   output logic signed [MUL_W-1:0]  prod
);

   logic signed [NIB_W:0] nib_s;

   assign nib_s = {1'b0, nib};
   assign prod  = nib_s * wide;

endmodule

// File: rtl/dlpe_accum.sv
module dlpe_accum #(
   parameter int unsigned ACC_W  = 24,
   parameter int unsigned PROD_W = 17
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic signed [PROD_W-1:0] addend,
   output logic [ACC_W-1:0]         total
);

   logic [ACC_W-1:0] addend_x;

   assign addend_x = {{(ACC_W-PROD_W){addend[PROD_W-1]}}, addend};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         total <= '0;
      end else if (restart) begin
         total <= addend_x;
      end else begin
         total <= total + addend_x;
      end
   end

endmodule

// File: rtl/dual_lane_pe.sv
module dual_lane_pe
   import dlpe_pkg::*;
#(
   parameter int unsigned ACT_W      = 8,
   parameter int unsigned WGT_W      = 8,
   parameter int unsigned ACC_W      = 24,
   parameter bit          ROUND_NEAR = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [2*ACT_W-1:0]     act_in,
   input  logic [2*WGT_W-1:0]     wgt_in,
   input  logic [1:0]             vld_in,
   input  logic [1:0]             clr_in,
   input  logic                   drain_in,
   output logic [2*ACT_W-1:0]     act_out,
   output logic [2*WGT_W-1:0]     wgt_out,
   output logic [1:0]             vld_out,
   output logic [2*ACC_W-1:0]     acc_out,
   output logic                   approx_flag
);

   localparam int unsigned NIB_W  = ACT_W / 2;
   localparam int unsigned WIDE_W = ACT_W + 1;
   localparam int unsigned MUL_W  = NIB_W + WIDE_W + 1;
   localparam int unsigned PROD_W = ACT_W + WGT_W + 1;

   // elaboration-time parameter checks
   if (ACT_W % 2 != 0 || ACT_W < 4) begin : g_bad_act
      $error("dual_lane_pe: ACT_W must be even and at least 4");
   end
   if (WGT_W != ACT_W) begin : g_bad_wgt
      $error("dual_lane_pe: WGT_W must equal ACT_W");
   end
   if (ACC_W <= PROD_W) begin : g_bad_acc
      $error("dual_lane_pe: ACC_W must exceed the product width");
   end

   logic [ACT_W-1:0]          act_t   [LANES];
   logic [WGT_W-1:0]          wgt_t   [LANES];
   logic                      live    [LANES];
   logic [NIB_W-1:0]          nib_p   [LANES];
   logic signed [WIDE_W-1:0]  wide_p  [LANES];
   logic                      shift_p [LANES];
   logic                      red_p   [LANES];
   logic [NIB_W-1:0]          mul_nib [LANES];
   logic signed [WIDE_W-1:0]  mul_wide[LANES];
   logic signed [MUL_W-1:0]   mul_p   [LANES];
   logic signed [PROD_W-1:0]  mul_x   [LANES];
   logic signed [PROD_W-1:0]  split_p [LANES];
   logic signed [PROD_W-1:0]  prod    [LANES];
   logic [ACC_W-1:0]          acc_q   [LANES];

   share_mode_e               mode;
   logic                      solo_sel;
   logic signed [PROD_W-1:0]  full_p;
   logic signed [WIDE_W-1:0]  solo_wide;

   // per-thread operand preparation, multiplier half and accumulator
   for (genvar t = 0; t < LANES; t++) begin : g_lane
      assign act_t[t] = act_in[t*ACT_W +: ACT_W];
      assign wgt_t[t] = wgt_in[t*WGT_W +: WGT_W];
      assign live[t]  = vld_in[t] && (act_t[t] != '0) && (wgt_t[t] != '0);

      dlpe_lane_prep #(
         .ACT_W      (ACT_W),
         .WGT_W      (WGT_W),
         .ROUND_NEAR (ROUND_NEAR)
      ) i_prep (
         .act      (act_t[t]),
         .wgt      (wgt_t[t]),
         .nib      (nib_p[t]),
         .wide     (wide_p[t]),
         .shift_up (shift_p[t]),
         .reduced  (red_p[t])
      );

      dlpe_nibble_mul #(
         .NIB_W  (NIB_W),
         .WIDE_W (WIDE_W)
      ) i_half (
         .nib  (mul_nib[t]),
         .wide (mul_wide[t]),
         .prod (mul_p[t])
      );

      assign mul_x[t]   = {{(PROD_W-MUL_W){mul_p[t][MUL_W-1]}}, mul_p[t]};
      assign split_p[t] = shift_p[t] ? (mul_x[t] <<< NIB_W) : mul_x[t];

      dlpe_accum #(
         .ACC_W  (ACC_W),
         .PROD_W (PROD_W)
      ) i_acc (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (clr_in[t]),
         .addend  (prod[t]),
         .total   (acc_q[t])
      );

      assign acc_out[t*ACC_W +: ACC_W] = drain_in ? acc_q[t] : '0;
   end

   // sharing decision: no thread ever waits
   always_comb begin
      if (live[0] && live[1]) begin
         mode = SHARE_SPLIT;
      end else if (live[0]) begin
         mode = SHARE_SOLO0;
      end else if (live[1]) begin
         mode = SHARE_SOLO1;
      end else begin
         mode = SHARE_IDLE;
      end
   end

   assign solo_sel  = (mode == SHARE_SOLO1);
   assign solo_wide = {{(WIDE_W-WGT_W){wgt_t[solo_sel][WGT_W-1]}}, wgt_t[solo_sel]};

   // steer the two multiplier halves
   always_comb begin
      for (int t = 0; t < LANES; t++) begin
         mul_nib[t]  = '0;
         mul_wide[t] = '0;
      end
      unique case (mode)
         SHARE_SPLIT: begin
            for (int t = 0; t < LANES; t++) begin
               mul_nib[t]  = nib_p[t];
               mul_wide[t] = wide_p[t];
            end
         end
         SHARE_SOLO0, SHARE_SOLO1: begin
            mul_nib[0]  = act_t[solo_sel][NIB_W-1:0];
            mul_nib[1]  = act_t[solo_sel][ACT_W-1:NIB_W];
            mul_wide[0] = solo_wide;
            mul_wide[1] = solo_wide;
         end
         default: ;
      endcase
   end

   // recombine the halves into one full-width product in solo modes
   assign full_p = mul_x[0] + (mul_x[1] <<< NIB_W);

   always_comb begin
      for (int t = 0; t < LANES; t++) begin
         prod[t] = '0;
      end
      unique case (mode)
         SHARE_SPLIT: begin
            for (int t = 0; t < LANES; t++) begin
               prod[t] = split_p[t];
            end
         end
         SHARE_SOLO0: prod[0] = full_p;
         SHARE_SOLO1: prod[1] = full_p;
         default: ;
      endcase
   end

   assign approx_flag = (mode == SHARE_SPLIT) && (red_p[0] || red_p[1]);

   // operand pass-through toward the neighbours
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_out <= '0;
         wgt_out <= '0;
         vld_out <= '0;
      end else begin
         act_out <= act_in;
         wgt_out <= wgt_in;
         vld_out <= vld_in;
      end
   end

endmodule

// File: rtl/dlpe_checker.sv
module dlpe_checker #(
   parameter int unsigned ACT_W = 8,
   parameter int unsigned WGT_W = 8,
   parameter int unsigned ACC_W = 24
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2*ACT_W-1:0] act_in,
   input logic [2*WGT_W-1:0] wgt_in,
   input logic [1:0]         vld_in,
   input logic [1:0]         clr_in,
   input logic               drain_in,
   input logic [2*ACT_W-1:0] act_out,
   input logic [2*WGT_W-1:0] wgt_out,
   input logic [1:0]         vld_out,
   input logic [2*ACC_W-1:0] acc_out,
   input logic               approx_flag
);

   logic past_ok;
   logic both_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign both_live = vld_in[0] && vld_in[1]
                      && (act_in[ACT_W-1:0] != '0) && (wgt_in[WGT_W-1:0] != '0)
                      && (act_in[2*ACT_W-1:ACT_W] != '0) && (wgt_in[2*WGT_W-1:WGT_W] != '0);

   assert_pass_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (act_out == $past(act_in) && wgt_out == $past(wgt_in)
                   && vld_out == $past(vld_in)));

   assert_flag_split_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      approx_flag |-> both_live);

   assert_drain_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !drain_in |-> (acc_out == '0));

   assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(clr_in[0] && !vld_in[0]) && drain_in)
      |-> (acc_out[ACC_W-1:0] == '0));

   assert_invalid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(drain_in && !vld_in[1] && !clr_in[1]) && drain_in)
      |-> (acc_out[2*ACC_W-1:ACC_W] == $past(acc_out[2*ACC_W-1:ACC_W])));

endmodule

bind dual_lane_pe dlpe_checker #(
   .ACT_W (ACT_W),
   .WGT_W (WGT_W),
   .ACC_W (ACC_W)
) i_dlpe_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .act_in      (act_in),
   .wgt_in      (wgt_in),
   .vld_in      (vld_in),
   .clr_in      (clr_in),
   .drain_in    (drain_in),
   .act_out     (act_out),
   .wgt_out     (wgt_out),
   .vld_out     (vld_out),
   .acc_out     (acc_out),
   .approx_flag (approx_flag)
);

// File: tb/test_dual_lane_pe.sv
module test_dual_lane_pe;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] act_in = '0;
   logic [15:0] wgt_in = '0;
   logic [1:0]  vld_in = '0;
   logic [1:0]  clr_in = '0;
   logic        drain_in = 1'b0;
   logic [15:0] act_out;
   logic [15:0] wgt_out;
   logic [1:0]  vld_out;
   logic [47:0] acc_out;
   logic        approx_flag;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [23:0] m_acc [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_lane_pe i_dual_lane_pe (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_in      (act_in),
      .wgt_in      (wgt_in),
      .vld_in      (vld_in),
      .clr_in      (clr_in),
      .drain_in    (drain_in),
      .act_out     (act_out),
      .wgt_out     (wgt_out),
      .vld_out     (vld_out),
      .acc_out     (acc_out),
      .approx_flag (approx_flag)
   );

   task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", what, got, exp);
      end
   endtask

   // reference product for one thread in split mode
   function automatic int lane_ref(input int a, input int w, output bit red);
      int r;
      red = 1'b0;
      if (a < 16) return a * w;
      if (w >= 0 && w < 16) return a * w;
      r = (a + 8) / 16;
      if (r > 15) r = 15;
      red = 1'b1;
      return r * w * 16;
   endfunction

   // one cycle of stimulus with model update and checks
   task automatic step(input string req, input int a0, input int w0, input int a1,
                       input int w1, input logic [1:0] v, input logic [1:0] c,
                       input logic dr);
      bit   l0, l1, r0, r1, apx;
      int   p0, p1;
      logic [15:0] a_drv, w_drv;
      logic [1:0]  v_drv;
      @(negedge clk);
      a_drv = {8'(a1), 8'(a0)};
      w_drv = {8'(w1), 8'(w0)};
      v_drv = v;
      act_in = a_drv; wgt_in = w_drv; vld_in = v; clr_in = c; drain_in = dr;
      l0 = v[0] && a0 != 0 && w0 != 0;
      l1 = v[1] && a1 != 0 && w1 != 0;
      p0 = 0; p1 = 0; r0 = 0; r1 = 0;
      if (l0 && l1) begin
         p0 = lane_ref(a0, w0, r0);
         p1 = lane_ref(a1, w1, r1);
      end else if (l0) begin
         p0 = a0 * w0;
      end else if (l1) begin
         p1 = a1 * w1;
      end
      apx = r0 | r1;
      #1;
      chk({"R7 approx_flag in ", req}, 64'(approx_flag), 64'(apx));
      m_acc[0] = c[0] ? 24'(p0) : m_acc[0] + 24'(p0);
      m_acc[1] = c[1] ? 24'(p1) : m_acc[1] + 24'(p1);
      @(posedge clk);
      #1;
      chk("R1 act_out", 64'(act_out), 64'(a_drv));
      chk("R1 wgt_out", 64'(wgt_out), 64'(w_drv));
      chk("R1 vld_out", 64'(vld_out), 64'(v_drv));
      if (dr) begin
         chk({req, " acc thread0"}, 64'(acc_out[23:0]),  64'(m_acc[0]));
         chk({req, " acc thread1"}, 64'(acc_out[47:24]), 64'(m_acc[1]));
      end else begin
         chk("R9 acc_out zero while not draining", 64'(acc_out), 64'd0);
      end
   endtask

   task automatic t_reset;
      drain_in = 1'b1;
      #1;
      chk("R10 reset acc_out", 64'(acc_out), 64'd0);
      chk("R1 reset act_out", 64'(act_out), 64'd0);
      chk("R1 reset wgt_out", 64'(wgt_out), 64'd0);
      chk("R1 reset vld_out", 64'(vld_out), 64'd0);
      chk("R7 reset approx_flag", 64'(approx_flag), 64'd0);
      m_acc[0] = '0;
      m_acc[1] = '0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_solo_full;
      step("R2 solo thread0", 200, -77, 0, 0, 2'b01, 2'b00, 1'b1);
      step("R2 solo max", 255, 127, 0, 0, 2'b01, 2'b00, 1'b1);
      step("R2 solo thread1 negative", 0, 0, 255, -128, 2'b10, 2'b00, 1'b1);
      // thread1 valid but zero weight: thread0 keeps full precision
      step("R2 zero weight partner", 250, -100, 77, 0, 2'b11, 2'b00, 1'b1);
      step("R2 zero activation partner", 0, 55, 199, 99, 2'b11, 2'b00, 1'b1);
   endtask

   task automatic t_split_exact;
      step("R4 split small activations", 9, -100, 15, 127, 2'b11, 2'b00, 1'b1);
      step("R5 split small weights", 200, 13, 130, 15, 2'b11, 2'b00, 1'b1);
      step("R4 R5 mixed", 3, -128, 255, 1, 2'b11, 2'b00, 1'b1);
   endtask

   task automatic t_split_reduced;
      step("R6 rounding", 100, -50, 250, 100, 2'b11, 2'b00, 1'b1);
      step("R6 saturation", 255, -128, 248, 16, 2'b11, 2'b00, 1'b1);
      step("R6 one lane reduced", 16, -1, 5, 5, 2'b11, 2'b00, 1'b1);
   endtask

   task automatic t_invalid;
      step("R3 invalid thread0", 180, 90, 120, -60, 2'b10, 2'b00, 1'b1);
      step("R3 invalid thread1", 140, -20, 250, 120, 2'b01, 2'b00, 1'b1);
   endtask

   task automatic t_clear;
      step("R8 clear thread0 live", 17, 3, 40, -40, 2'b11, 2'b01, 1'b1);
      step("R8 clear thread1 idle", 30, 30, 90, 90, 2'b01, 2'b10, 1'b1);
      step("R8 accumulate after clear", 2, 2, 0, 0, 2'b01, 2'b00, 1'b1);
   endtask

   task automatic t_drain;
      step("R9 drain low", 11, 11, 12, 12, 2'b11, 2'b00, 1'b0);
      step("R9 drain restored", 0, 0, 0, 0, 2'b00, 2'b00, 1'b1);
   endtask

   task automatic t_wrap;
      step("R10 wrap start", 255, -128, 0, 0, 2'b01, 2'b11, 1'b1);
      for (int i = 0; i < 299; i++) begin
         step("R10 wrap run", 255, -128, 0, 0, 2'b01, 2'b00, 1'b1);
      end
      // -32640*300 lies below -2^23, so the model value has wrapped
      chk("R10 wrapped result", 64'(acc_out[23:0]), 64'(24'(-32640 * 300)));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_solo_full();
      t_split_exact();
      t_split_reduced();
      t_invalid();
      t_clear();
      t_drain();
      t_wrap();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule